// File: doc/BRIEF.md
# Taken-Branch Squash Unit

This block is the control-hazard logic of a five-stage pipeline that keeps fetching past a conditional branch without waiting for its outcome. Each cycle the fetch stage presents a control bundle for the word at the current fetch address. That bundle holds the branch flag, the register and memory write enables, a 16-bit offset and two operand values. The bundle travels through four control pipeline registers: fetch/decode, decode/execute, execute/memory and memory/writeback. In the execute stage the block compares the two operands to form the zero flag and adds the branch target. Both results ride into the memory stage with the branch.

While a branch sits in the memory stage with the zero flag set, the block switches the PC source to the branch target. In that same cycle it clears the three bundles that are being written into the fetch/decode, decode/execute and execute/memory registers to all-zero NOPs. Those three younger instructions can then never raise a data-memory write in the memory stage or a register write in writeback. Fetch never pauses. The word fetched in the following cycle is the target, and it proceeds normally.

A small two-state controller sequences the redirect. In state `RS_FLOW` the pipeline streams. The transition *redirect* fires on a taken branch and moves to `RS_REFILL` for the one cycle in which the target is fetched. The transition *refill_done* then returns unconditionally to `RS_FLOW`. A redirect is never raised from `RS_REFILL`.

Top module: `branch_squash_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `fetch_pc` equals `RESET_PC` (default 0), and `pc_sel`, all three kill outputs, `mem_we` and `wb_reg_we` are 0.
- R2: In any cycle with `pc_sel` low, the next cycle's `fetch_pc` is the current one plus 4. Fetch never holds.
- R3: A valid branch in the memory stage is taken exactly when its two operands, sampled in execute, are equal. A branch with unequal operands raises neither `pc_sel` nor any kill.
- R4: The redirect address `next_pc` is the branch address plus 4, plus the sign-extended 16-bit offset shifted left by 2, modulo 2^AW. It is the fetch address of the cycle after `pc_sel`. For example, a branch at 8 with offset 7 goes to 40, and a branch at 112 with offset -21 goes to 32.
- R5: In the cycle a taken branch is in the memory stage, `pc_sel`, `kill_fd`, `kill_dx` and `kill_xm` are all 1. The three fetches after that branch (its address plus 4, 8 and 12) are the squashed ones.
- R6: A squashed instruction never asserts `mem_we` in the memory stage and never asserts `wb_reg_we` in writeback, whatever write enables it was fetched with.
- R7: The instruction fetched in the cycle after `pc_sel` (the target) is never squashed by that branch. This holds even when its address equals that of one of the squashed instructions, and even when it is itself a taken branch.
- R8: After a not-taken branch, the three following instructions complete and perform their writes in program order.
- R9: A branch that was squashed never raises `pc_sel` or changes the fetch sequence. In particular `pc_sel` is never high in two consecutive cycles.
- R10: Forward and backward offsets both redirect correctly, and two taken branches may follow each other back to back on the correct path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_pc | output | AW | Address being fetched this cycle |
| if_is_branch | input | 1 | Fetched word is a branch-if-equal |
| if_reg_we | input | 1 | Fetched word writes the register file |
| if_mem_we | input | 1 | Fetched word writes data memory |
| if_imm | input | 16 | Fetched word's signed word offset |
| if_opa | input | DW | First compare operand of the fetched word |
| if_opb | input | DW | Second compare operand of the fetched word |
| pc_sel | output | 1 | 1: next fetch comes from `next_pc` target; 0: sequential |
| next_pc | output | AW | Address that will be fetched next cycle |
| kill_fd | output | 1 | Bundle entering fetch/decode is replaced by a NOP |
| kill_dx | output | 1 | Bundle entering decode/execute is replaced by a NOP |
| kill_xm | output | 1 | Bundle entering execute/memory is replaced by a NOP |
| mem_we | output | 1 | Data-memory write from the memory-stage instruction |
| mem_pc | output | AW | Address of the memory-stage instruction |
| wb_reg_we | output | 1 | Register-file write from the writeback instruction |
| wb_pc | output | AW | Address of the writeback instruction |

## Verification
One program exercises the block, and every word in it carries write enables, so any instruction that escapes squashing shows up as an unexpected write. A taken forward branch whose shadow holds both kinds of write separates squashing from plain sequential flow. A not-taken branch followed by writes shows that squashing is tied to the zero flag and is not raised by every branch. A taken branch aimed into its own shadow, followed at once by another taken branch, tells apart squashing by address from squashing by position. A killed branch that would be taken, and a backward branch into code whose earlier copy was squashed, cover the remaining orderings. The exact fetch address stream is compared cycle by cycle, so a missing or extra shadow slot is visible at once.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

    // Width of the branch offset field carried by each fetched word.
    localparam int IMM_W      = 16;
    // Byte distance between two consecutive instruction words.
    localparam int WORD_BYTES = 4;
    // Number of younger pipeline registers cleared on a taken branch.
    localparam int SHADOW_N   = 3;

    // Redirect controller states.
    typedef enum logic [0:0] {
        RS_FLOW   = 1'b0,   // streaming, no redirect in progress
        RS_REFILL = 1'b1    // target is being fetched this cycle
    } redirect_state_e;

endpackage

// File: rtl/bsq_stage_reg.sv
module bsq_stage_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         kill,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // A killed stage loads the all-zero NOP bundle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (kill) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/bsq_exec_eval.sv
module bsq_exec_eval #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic [AW-1:0]              pc,
    input  logic [bsq_pkg::IMM_W-1:0]  imm,
    input  logic [DW-1:0]              opa,
    input  logic [DW-1:0]              opb,
    output logic                       zero,
    output logic [AW-1:0]              target
);

    localparam int SHIFT  = $clog2(bsq_pkg::WORD_BYTES);
    localparam int EXT_W  = AW - bsq_pkg::IMM_W - SHIFT;

    logic [DW-1:0] diff;
    logic [AW-1:0] offset_bytes;
    logic [AW-1:0] seq_pc;

    // Zero check: operand difference is zero when the branch is taken.
    assign diff = opa - opb;
    assign zero = (diff == '0);

    // Target adder: (pc + word) + sign-extended offset in words.
    assign offset_bytes = {{EXT_W{imm[bsq_pkg::IMM_W-1]}}, imm, {SHIFT{1'b0}}};
    assign seq_pc       = pc + AW'(bsq_pkg::WORD_BYTES);
    assign target       = seq_pc + offset_bytes;

endmodule

// File: rtl/bsq_fetch_pc.sv
module bsq_fetch_pc #(
    parameter int          AW       = 32,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pc_sel,
    input  logic [AW-1:0] redirect_pc,
    output logic [AW-1:0] fetch_pc,
    output logic [AW-1:0] next_pc
);

    logic [AW-1:0] pc_q;

    // PC-source mux: sequential word or resolved branch target.
    always_comb begin
        if (pc_sel) begin
            next_pc = redirect_pc;
        end else begin
            next_pc = pc_q + AW'(bsq_pkg::WORD_BYTES);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= AW'(RESET_PC);
        end else begin
            pc_q <= next_pc;
        end
    end

    assign fetch_pc = pc_q;

endmodule

// File: rtl/bsq_redirect_ctl.sv
module bsq_redirect_ctl #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mem_valid,
    input  logic          mem_branch,
    input  logic          mem_zero,
    input  logic [AW-1:0] mem_target,
    output logic          pc_sel,
    output logic [AW-1:0] redirect_pc,
    output logic [bsq_pkg::SHADOW_N-1:0] kill_vec
);

    import bsq_pkg::*;

    redirect_state_e state_q;
    redirect_state_e state_d;
    logic            resolve_taken;

    // A squashed branch is a NOP bundle: valid and branch flags are zero.
    assign resolve_taken = mem_valid & mem_branch & mem_zero;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_FLOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and outputs.
    always_comb begin
        state_d     = state_q;
        pc_sel      = 1'b0;
        kill_vec    = '0;
        redirect_pc = mem_target;
        unique case (state_q)
            RS_FLOW: begin
                if (resolve_taken) begin
                    // transition: redirect
                    pc_sel   = 1'b1;
                    kill_vec = '1;
                    state_d  = RS_REFILL;
                end
            end
            RS_REFILL: begin
                // transition: refill_done (target fetch is protected)
                state_d = RS_FLOW;
            end
            default: begin
                state_d = RS_FLOW;
            end
        endcase
    end

endmodule

// File: rtl/branch_squash_unit.sv
module branch_squash_unit #(
    parameter int          AW       = 32,
    parameter int          DW       = 32,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    output logic [AW-1:0]             fetch_pc,
    input  logic                      if_is_branch,
    input  logic                      if_reg_we,
    input  logic                      if_mem_we,
    input  logic [bsq_pkg::IMM_W-1:0] if_imm,
    input  logic [DW-1:0]             if_opa,
    input  logic [DW-1:0]             if_opb,
    output logic                      pc_sel,
    output logic [AW-1:0]             next_pc,
    output logic                      kill_fd,
    output logic                      kill_dx,
    output logic                      kill_xm,
    output logic                      mem_we,
    output logic [AW-1:0]             mem_pc,
    output logic                      wb_reg_we,
    output logic [AW-1:0]             wb_pc
);

    import bsq_pkg::*;

    // Pipeline register indices.
    localparam int FD    = 0;
    localparam int DX    = 1;
    localparam int XM    = 2;
    localparam int MW    = 3;
    localparam int NSTG  = 4;

    typedef struct packed {
        logic             valid;
        logic             is_branch;
        logic             reg_we;
        logic             mem_we;
        logic [IMM_W-1:0] imm;
        logic [DW-1:0]    opa;
        logic [DW-1:0]    opb;
        logic             zero;
        logic [AW-1:0]    target;
        logic [AW-1:0]    pc;
    } stage_t;

    localparam int SW = $bits(stage_t);

    stage_t              stg_d [NSTG];
    stage_t              stg_q [NSTG];
    logic [NSTG-1:0]     kill_v;
    logic [SHADOW_N-1:0] kill_shadow;
    logic                ex_zero;
    logic [AW-1:0]       ex_target;
    logic [AW-1:0]       redirect_pc;

    // Fetch bundle: fetch always produces a valid word.
    always_comb begin
        stg_d[FD]           = '0;
        stg_d[FD].valid     = 1'b1;
        stg_d[FD].is_branch = if_is_branch;
        stg_d[FD].reg_we    = if_reg_we;
        stg_d[FD].mem_we    = if_mem_we;
        stg_d[FD].imm       = if_imm;
        stg_d[FD].opa       = if_opa;
        stg_d[FD].opb       = if_opb;
        stg_d[FD].pc        = fetch_pc;
    end

    // Execute stage: zero check and target adder.
    bsq_exec_eval #(.AW(AW), .DW(DW)) u_exec (
        .pc     (stg_q[DX].pc),
        .imm    (stg_q[DX].imm),
        .opa    (stg_q[DX].opa),
        .opb    (stg_q[DX].opb),
        .zero   (ex_zero),
        .target (ex_target)
    );

    always_comb begin
        stg_d[DX]        = stg_q[FD];
        stg_d[XM]        = stg_q[DX];
        stg_d[XM].zero   = ex_zero;
        stg_d[XM].target = ex_target;
        stg_d[MW]        = stg_q[XM];
    end

    // Branch resolution in the memory stage.
    bsq_redirect_ctl #(.AW(AW)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .mem_valid   (stg_q[XM].valid),
        .mem_branch  (stg_q[XM].is_branch),
        .mem_zero    (stg_q[XM].zero),
        .mem_target  (stg_q[XM].target),
        .pc_sel      (pc_sel),
        .redirect_pc (redirect_pc),
        .kill_vec    (kill_shadow)
    );

    // The memory/writeback register is never cleared by a redirect.
    assign kill_v = {1'b0, kill_shadow};

    generate
        for (genvar s = 0; s < NSTG; s++) begin : g_stage
            bsq_stage_reg #(.W(SW)) u_reg (
                .clk   (clk),
                .rst_n (rst_n),
                .kill  (kill_v[s]),
                .d     (stg_d[s]),
                .q     (stg_q[s])
            );
        end
    endgenerate

    bsq_fetch_pc #(.AW(AW), .RESET_PC(RESET_PC)) u_pc (
        .clk         (clk),
        .rst_n       (rst_n),
        .pc_sel      (pc_sel),
        .redirect_pc (redirect_pc),
        .fetch_pc    (fetch_pc),
        .next_pc     (next_pc)
    );

    assign kill_fd   = kill_v[FD];
    assign kill_dx   = kill_v[DX];
    assign kill_xm   = kill_v[XM];
    assign mem_we    = stg_q[XM].valid & stg_q[XM].mem_we;
    assign mem_pc    = stg_q[XM].pc;
    assign wb_reg_we = stg_q[MW].valid & stg_q[MW].reg_we;
    assign wb_pc     = stg_q[MW].pc;

endmodule

// File: rtl/bsq_checker.sv
module bsq_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] fetch_pc,
    input logic [AW-1:0] next_pc,
    input logic          pc_sel,
    input logic          kill_fd,
    input logic          kill_dx,
    input logic          kill_xm,
    input logic          mem_we,
    input logic          wb_reg_we
);

    // R2
    seq_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_sel |=> fetch_pc == $past(fetch_pc) + AW'(4));

    // R4
    redirect_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_sel |=> fetch_pc == $past(next_pc));

    // R9
    no_double_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_sel |=> !pc_sel);

    // R7
    target_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill_fd |=> !kill_fd && !kill_dx && !kill_xm);

    // R6
    xm_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill_xm |=> !mem_we);

    // R6
    dx_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill_dx |=> ##1 !mem_we);

    // R6
    xm_no_regwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill_xm |=> ##1 !wb_reg_we);

endmodule

bind branch_squash_unit bsq_checker #(.AW(AW)) u_bsq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_pc  (fetch_pc),
    .next_pc   (next_pc),
    .pc_sel    (pc_sel),
    .kill_fd   (kill_fd),
    .kill_dx   (kill_dx),
    .kill_xm   (kill_xm),
    .mem_we    (mem_we),
    .wb_reg_we (wb_reg_we)
);

// File: tb/tb_branch_squash_unit.sv
module tb_branch_squash_unit;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int END_PC = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] fetch_pc;
    logic          if_is_branch, if_reg_we, if_mem_we;
    logic [15:0]   if_imm;
    logic [DW-1:0] if_opa, if_opb;
    logic          pc_sel, kill_fd, kill_dx, kill_xm, mem_we, wb_reg_we;
    logic [AW-1:0] next_pc, mem_pc, wb_pc;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit running = 1'b0;

    logic [AW-1:0] fetch_q[$];
    logic [AW-1:0] redir_q[$];
    logic [AW-1:0] store_q[$];
    logic [AW-1:0] regw_q[$];

    always #10 clk = ~clk;  // 50 MHz

    branch_squash_unit #(.AW(AW), .DW(DW), .RESET_PC(32'h0)) dut (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
        .if_is_branch(if_is_branch), .if_reg_we(if_reg_we), .if_mem_we(if_mem_we),
        .if_imm(if_imm), .if_opa(if_opa), .if_opb(if_opb),
        .pc_sel(pc_sel), .next_pc(next_pc),
        .kill_fd(kill_fd), .kill_dx(kill_dx), .kill_xm(kill_xm),
        .mem_we(mem_we), .mem_pc(mem_pc), .wb_reg_we(wb_reg_we), .wb_pc(wb_pc)
    );

    // Program word: {branch, reg_we, mem_we, imm, opa, opb}
    typedef struct packed {
        logic        br;
        logic        rwe;
        logic        mwe;
        logic [15:0] imm;
        logic [7:0]  a;
        logic [7:0]  b;
    } word_t;

    function automatic word_t rom(input logic [AW-1:0] pc);
        word_t w = '0;
        case (pc >> 2)
            0:  w.rwe = 1;
            1:  w.mwe = 1;
            2:  begin w.br = 1; w.imm = 16'd7;    w.a = 5; w.b = 5; end
            3:  w.rwe = 1;
            4:  w.mwe = 1;
            5:  begin w.rwe = 1; w.mwe = 1; end
            6, 7, 8, 10, 13, 15, 22, 24, 25, 26, 29, 30: w.rwe = 1;
            9:  begin w.br = 1; w.imm = 16'd20;   w.a = 0; w.b = 0; end
            11: begin w.br = 1; w.imm = 16'd3;    w.a = 1; w.b = 2; end
            12, 23, 27, 31: w.mwe = 1;
            14: begin w.br = 1; w.imm = 16'd1;    w.a = 7; w.b = 7; end
            16: begin w.br = 1; w.imm = 16'd3;    w.a = 3; w.b = 3; end
            17, 19: w.rwe = 1;
            18: w.mwe = 1;
            20: begin w.br = 1; w.imm = 16'd5;    w.a = 9; w.b = 9; end
            21: begin w.br = 1; w.imm = 16'hFFFB; w.a = 0; w.b = 0; end
            28: begin w.br = 1; w.imm = 16'hFFEB; w.a = 2; w.b = 2; end
            default: w = '0;
        endcase
        return w;
    endfunction

    word_t cur;
    assign cur          = rom(fetch_pc);
    assign if_is_branch = cur.br;
    assign if_reg_we    = cur.rwe;
    assign if_mem_we    = cur.mwe;
    assign if_imm       = cur.imm;
    assign if_opa       = DW'(cur.a);
    assign if_opb       = DW'(cur.b);

    task automatic check(input bit ok, input string req, input logic [AW-1:0] act,
                         input logic [AW-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Driver: walks the program in order and pushes expected items.
    task automatic build_expect();
        logic [AW-1:0] pc = 0;
        int guard = 0;
        while (pc < END_PC && guard < 200) begin
            word_t w = rom(pc);
            guard++;
            fetch_q.push_back(pc);
            if (w.mwe) store_q.push_back(pc);
            if (w.rwe) regw_q.push_back(pc);
            if (w.br && w.a == w.b) begin
                logic [AW-1:0] tgt;
                tgt = pc + 4 + {{14{w.imm[15]}}, w.imm, 2'b00};
                redir_q.push_back(tgt);
                // shadow fetches (R5)
                for (int k = 1; k <= 3; k++) fetch_q.push_back(pc + AW'(4 * k));
                pc = tgt;
            end else begin
                pc = pc + 4;
            end
        end
    endtask

    // Monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            // R1 reset state
            check(fetch_pc == 0 && !pc_sel && !kill_fd && !kill_dx && !kill_xm
                  && !mem_we && !wb_reg_we, "R1", fetch_pc, 0);
        end else if (running) begin
            if (fetch_q.size() > 0) begin
                // R2 R7 R10 exact fetch stream
                check(fetch_pc == fetch_q[0], "R2/R7 fetch", fetch_pc, fetch_q[0]);
                void'(fetch_q.pop_front());
            end
            // R5 kill all three with the redirect
            if (kill_fd || kill_dx || kill_xm || pc_sel)
                check(pc_sel && kill_fd && kill_dx && kill_xm, "R5 kills",
                      {kill_fd, kill_dx, kill_xm, pc_sel}, 4'hF);
            if (pc_sel) begin
                // R3 R4 R9 redirect target
                if (redir_q.size() > 0) begin
                    check(next_pc == redir_q[0], "R4 target", next_pc, redir_q[0]);
                    void'(redir_q.pop_front());
                end else check(1'b0, "R3/R9 extra redirect", next_pc, 0);
            end
            if (mem_we) begin
                // R6 R8 stores
                if (store_q.size() > 0) begin
                    check(mem_pc == store_q[0], "R6/R8 store", mem_pc, store_q[0]);
                    void'(store_q.pop_front());
                end else check(1'b0, "R6 stray store", mem_pc, 0);
            end
            if (wb_reg_we) begin
                if (regw_q.size() > 0) begin
                    check(wb_pc == regw_q[0], "R6/R8 regwrite", wb_pc, regw_q[0]);
                    void'(regw_q.pop_front());
                end else check(1'b0, "R6 stray regwrite", wb_pc, 0);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            check(1'b0, "watchdog", AW'(cycles), 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        build_expect();
        repeat (3) @(posedge clk);
        @(posedge clk);
        #2 rst_n = 1'b1;
        running = 1'b1;
        repeat (90) @(posedge clk);
        @(negedge clk);
        // R10 every expected fetch, redirect and write has been seen
        check(fetch_q.size() == 0, "R10 fetch drained", AW'(fetch_q.size()), 0);
        check(redir_q.size() == 0, "R3 redirects drained", AW'(redir_q.size()), 0);
        check(store_q.size() == 0, "R8 stores drained", AW'(store_q.size()), 0);
        check(regw_q.size() == 0, "R8 regwrites drained", AW'(regw_q.size()), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule